// File: doc/BRIEF.md
# Integer Twin Butterfly Rounding Unit

This unit performs one integer butterfly step of a DCT or FFT. Each accepted request has an accumulator operand, a second operand, a signed coefficient and a shift amount. The unit forms the sum and the difference of the two operands. It multiplies each of them by the coefficient, keeping only the low XLEN bits of each product. It then rounds each product to nearest and shifts it right arithmetically by the programmed amount. Both results come out together, one clock after the request.

The primary result is the value written back over the accumulator operand, because the operation is read-modify-write. The secondary result is the difference path, which a register file would write to the register after the primary. A request with the record bit set is a reserved encoding. The unit rejects it with an illegal flag and produces no result.

With XLEN=32 and a shift of 14, each output equals `((x0 ± x1) * c + 8192) >> 14`, which is the usual rounding used by forward DCT kernels.

Top module: `twin_bfly_round`

## Requirements
- R1: The sum path uses acc + opb and the difference path uses acc - opb, both wrapping modulo 2^XLEN.
- R2: Each path multiplies its combined value as a signed number by the coefficient and keeps only the low XLEN bits of the product.
- R3: When shamt is 0, each result equals its kept product unchanged, with no rounding constant added.
- R4: When shamt = n > 0, the value 2^(n-1) is added to each kept product before shifting, and the add wraps within XLEN bits.
- R5: After rounding, each value is shifted right by n. The top n bits are filled with bit XLEN-1 of the rounded value before the shift (arithmetic shift).
- R6: res_pri carries the sum-path result and res_sec carries the difference-path result of the same request, and both update in the same cycle.
- R7: A request with rec_bit = 1 raises illegal for exactly one cycle and does not raise out_valid. The results keep their values after a rejected request and in every cycle without a request.
- R8: out_valid is high in exactly the cycle after a legal request (in_valid = 1, rec_bit = 0) and low otherwise.
- R9: A synchronous active-high reset clears out_valid, illegal, res_pri and res_sec to 0.
- R10: With XLEN=32 and shamt=14, each result equals ((acc ± opb) * coef + 8192) >>> 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| rec_bit | input | 1 | Record bit; 1 is reserved and rejected |
| shamt | input | 5 | Rounding shift amount n |
| op_acc | input | XLEN | Accumulator operand (destination) |
| op_b | input | XLEN | Second operand |
| coef | input | XLEN | Signed coefficient |
| out_valid | output | 1 | Results valid |
| illegal | output | 1 | Reserved request rejected |
| res_pri | output | XLEN | Sum-path result |
| res_sec | output | XLEN | Difference-path result |

## Verification
The assertions check several properties on every cycle. They check the one-cycle valid latency and the suppression of valid on a reserved request. They check that the results hold after a rejected or absent request. They also check that a zero shift passes the kept product straight through. The arithmetic itself can only be shown by the bench's scenarios. These cover wrap-around of the sum and of the rounding add, sign fill at n = XLEN-1, the most negative operand, a zero coefficient, the DCT case n=14, and random operands compared with a model built from the requirements.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
    localparam int SH_W = 5;

    typedef enum logic {
        LANE_SUM  = 1'b0,
        LANE_DIFF = 1'b1
    } lane_e;

    typedef struct packed {
        logic          valid;
        logic          reserved;
        logic [SH_W-1:0] shamt;
    } req_ctl_t;

    function automatic logic is_legal(req_ctl_t c);
        return c.valid && !c.reserved;
    endfunction

    function automatic logic is_rejected(req_ctl_t c);
        return c.valid && c.reserved;
    endfunction
endpackage

// File: rtl/tbr_rshift.sv
module tbr_rshift
    import tbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] prod_lo,
    input  logic [SH_W-1:0] shamt,
    output logic [XLEN-1:0] result
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    logic [XLEN-1:0] rnd_const;
    logic [XLEN-1:0] rounded;

    always_comb begin
        if (shamt == '0) begin
            rnd_const = '0;
        end else begin
            rnd_const = ONE << (shamt - SH_W'(1));
        end
        rounded = prod_lo + rnd_const;
        result  = XLEN'($signed(rounded) >>> shamt);
    end
endmodule

// File: rtl/tbr_lane.sv
module tbr_lane
    import tbr_pkg::*;
#(
    parameter int    XLEN = 32,
    parameter lane_e KIND = LANE_SUM
) (
    input  logic [XLEN-1:0] op_acc,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] coef,
    input  logic [SH_W-1:0] shamt,
    output logic [XLEN-1:0] result
);
    logic [XLEN-1:0] combined;
    logic [XLEN-1:0] prod_lo;

    generate
        if (KIND == LANE_DIFF) begin : g_diff
            assign combined = op_acc - op_b;
        end else begin : g_sum
            assign combined = op_acc + op_b;
        end
    endgenerate

    // Low half of a two's-complement product is sign-agnostic.
    assign prod_lo = combined * coef;

    tbr_rshift #(.XLEN(XLEN)) u_rshift (
        .prod_lo (prod_lo),
        .shamt   (shamt),
        .result  (result)
    );

    always_comb begin
        if (shamt == '0) begin
            AST_ZERO_SHIFT_BYPASS: assert (result == prod_lo); // R3
        end
    end
endmodule

// File: rtl/twin_bfly_round.sv
module twin_bfly_round
    import tbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            rec_bit,
    input  logic [4:0]      shamt,
    input  logic [XLEN-1:0] op_acc,
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] coef,
    output logic            out_valid,
    output logic            illegal,
    output logic [XLEN-1:0] res_pri,
    output logic [XLEN-1:0] res_sec
);
    localparam int NLANE = 2;

    typedef struct packed {
        logic [XLEN-1:0] pri;
        logic [XLEN-1:0] sec;
    } pair_t;

    req_ctl_t          ctl;
    logic [XLEN-1:0]   lane_res [NLANE];
    pair_t             nxt_pair;
    pair_t             out_pair;
    logic              vld_q;
    logic              ill_q;

    assign ctl = '{valid: in_valid, reserved: rec_bit, shamt: shamt};

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            tbr_lane #(
                .XLEN (XLEN),
                .KIND ((g == 0) ? LANE_SUM : LANE_DIFF)
            ) u_lane (
                .op_acc (op_acc),
                .op_b   (op_b),
                .coef   (coef),
                .shamt  (ctl.shamt),
                .result (lane_res[g])
            );
        end
    endgenerate

    assign nxt_pair = '{pri: lane_res[0], sec: lane_res[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= 1'b0;
            ill_q    <= 1'b0;
            out_pair <= '0;
        end else begin
            vld_q <= is_legal(ctl);
            ill_q <= is_rejected(ctl);
            if (is_legal(ctl)) begin
                out_pair <= nxt_pair;
            end
        end
    end

    assign out_valid = vld_q;
    assign illegal   = ill_q;
    assign res_pri   = out_pair.pri;
    assign res_sec   = out_pair.sec;

    AST_VALID_AFTER_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rec_bit) |=> out_valid); // R8
    AST_NO_VALID_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && !rec_bit) |=> !out_valid); // R8
    AST_RESERVED_REJECT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rec_bit) |=> (illegal && !out_valid)); // R7
    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && !rec_bit) |=> ($stable(res_pri) && $stable(res_sec))); // R7
endmodule

// File: tb/twin_bfly_round_tb_top.sv
module twin_bfly_round_tb_top;
    localparam int XLEN = 32;
    localparam int NVEC = 9;

    // columns: acc, opb, coef, shamt, expected primary, expected secondary
    localparam int VEC [NVEC][6] = '{
        '{100, 28, 11585, 14, 91, 51},                  // R10 DCT rounding
        '{5, -3, 7, 0, 14, 56},                         // R3 no rounding
        '{-100, 0, 3, 2, -75, -75},                     // R5 negative floor
        '{1, 1, 1, 1, 1, 0},                            // R4 round constant bit 0
        '{3, 0, 1, 1, 2, 2},                            // R4
        '{123, 45, 0, 3, 0, 0},                         // R2 zero coefficient
        '{32'h40000000, 0, 1, 31, -1, -1},              // R4/R5 wrap then sign fill
        '{32'h80000000, 0, -1, 0, 32'h80000000, 32'h80000000}, // R2 most negative
        '{32'h80000000, 1, 1, 0, 32'h80000001, 32'h7FFFFFFF}   // R1 wrap
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            rec_bit = 1'b0;
    logic [4:0]      shamt = '0;
    logic [XLEN-1:0] op_acc = '0;
    logic [XLEN-1:0] op_b = '0;
    logic [XLEN-1:0] coef = '0;
    logic            out_valid;
    logic            illegal;
    logic [XLEN-1:0] res_pri;
    logic [XLEN-1:0] res_sec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twin_bfly_round #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .rec_bit(rec_bit),
        .shamt(shamt), .op_acc(op_acc), .op_b(op_b), .coef(coef),
        .out_valid(out_valid), .illegal(illegal),
        .res_pri(res_pri), .res_sec(res_sec)
    );

    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                          logic [31:0] c, logic [4:0] n, bit dif);
        logic [31:0] s;
        logic [31:0] p;
        logic [31:0] r;
        s = dif ? a - b : a + b;
        p = s * c;
        if (n == 0) return p;
        r = p + (32'd1 << (n - 1));
        return 32'($signed(r) >>> n);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         logic [4:0] n, logic rb);
        @(negedge clk);
        op_acc = a; op_b = b; coef = c; shamt = n; rec_bit = rb; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rec_bit = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_p;
        logic [31:0] held_s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9 out_valid", {31'd0, out_valid}, 0);
        chk("R9 illegal", {31'd0, illegal}, 0);
        chk("R9 res_pri", res_pri, 0);
        chk("R9 res_sec", res_sec, 0);

        // Vector table: R1 R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][0], VEC[i][1], VEC[i][2], 5'(VEC[i][3]), 1'b0);
            chk($sformatf("R8 valid row %0d", i), {31'd0, out_valid}, 1);
            chk($sformatf("R6 primary row %0d", i), res_pri, VEC[i][4]);
            chk($sformatf("R6 secondary row %0d", i), res_sec, VEC[i][5]);
            @(negedge clk);
            chk($sformatf("R8 valid drops row %0d", i), {31'd0, out_valid}, 0);
            chk($sformatf("R7 hold row %0d", i), res_pri, VEC[i][4]);
        end

        // R7 reserved record bit rejected, results held
        held_p = res_pri; held_s = res_sec;
        drive(32'd999, 32'd1, 32'd77, 5'd3, 1'b1);
        chk("R7 illegal raised", {31'd0, illegal}, 1);
        chk("R7 no valid", {31'd0, out_valid}, 0);
        chk("R7 primary held", res_pri, held_p);
        chk("R7 secondary held", res_sec, held_s);
        @(negedge clk);
        chk("R7 illegal one cycle", {31'd0, illegal}, 0);

        // R8 back-to-back requests
        @(negedge clk);
        op_acc = 32'd10; op_b = 32'd4; coef = 32'd3; shamt = 5'd0; in_valid = 1'b1;
        @(negedge clk);
        chk("R8 b2b first valid", {31'd0, out_valid}, 1);
        chk("R6 b2b first pri", res_pri, 32'd42);
        chk("R6 b2b first sec", res_sec, 32'd18);
        op_acc = 32'd7; op_b = 32'd9; coef = 32'd2; shamt = 5'd0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 b2b second valid", {31'd0, out_valid}, 1);
        chk("R1 b2b second sec", res_sec, 32'hFFFFFFFC);

        // Random operands against model: R1 R2 R3 R4 R5
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a;
            logic [31:0] b;
            logic [31:0] c;
            logic [4:0]  n;
            a = $urandom; b = $urandom; c = $urandom; n = 5'($urandom);
            if (k % 4 == 0) c = {{16{c[15]}}, c[15:0]};
            drive(a, b, c, n, 1'b0);
            chk($sformatf("R4 rand pri %0d", k), res_pri, model(a, b, c, n, 1'b0));
            chk($sformatf("R5 rand sec %0d", k), res_sec, model(a, b, c, n, 1'b1));
        end

        // R9 reset mid-run clears state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 res_pri after reset", res_pri, 0);
        chk("R9 out_valid after reset", {31'd0, out_valid}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule